// File: doc/BRIEF.md
# Single-Wire Bus Slave ROM Command Layer

This block is the network layer of a slave device on a single-wire, open-drain bus. A bit-level physical layer below it supplies a pulse for each bus reset, each bit the master writes, and each read slot the master opens. The block then takes in an 8-bit command after every bus reset. The command bits arrive least significant bit first. The block then runs one of seven addressing commands against a 64-bit identity that is fixed as a parameter. Bit 0 of the identity is the low bit of an 8-bit family code. A 48-bit serial number sits above the family code, and the top byte holds a check byte over the lower 56 bits.

During read slots the block supplies the bit the slave must return. It also raises a request telling the physical layer to drive the bus in that slot. The block keeps the fast-timing (overdrive) flag that the physical layer uses to choose its slot timing. When an addressing command completes successfully, the block raises an enable that hands the bus to the memory/function layer. That enable stays high until the next bus reset.

Top module: `sw_rom_net`

## Requirements
- R1: After the synchronous reset `rst`, `overdrive`, `fn_en` and `rd_drv` are 0, and every slot is ignored until the first bus reset event.
- R2: A bus reset event (`rst_evt`) clears `fn_en`, stops any command in progress, and makes the block collect a fresh 8-bit command from the next eight write slots, least significant bit first.
- R3: Command 33h sets `rd_drv`=1 for the next 64 read slots. Slot k returns identity bit k, starting at bit 0. After slot 64 `fn_en` rises and `rd_drv` falls.
- R4: Command 55h compares the next 64 written bits with the identity, bit 0 first. If all of them match, `fn_en` rises. On the first mismatch the block goes quiet: it does not drive, does not enable, and ignores every slot until a bus reset.
- R5: Command F0h handles each identity bit k in three slots: a read slot returning bit k, a read slot returning its complement, then a write slot carrying the master's choice. A choice that differs from bit k makes the block go quiet. After all 64 positions `fn_en` rises.
- R6: Command ECh acts like F0h if `alarm_in` is 1 when the last command bit arrives. Otherwise the block goes quiet.
- R7: Command CCh raises `fn_en` right after the command byte, with no address phase.
- R8: Command 3Ch sets `overdrive` and raises `fn_en` right after the command byte.
- R9: Command 69h runs the same 64-bit comparison as 55h. It sets `overdrive` only when all 64 bits match, and a mismatch leaves `overdrive` unchanged.
- R10: A bus reset with `rst_std_len`=1 clears `overdrive`. A bus reset with `rst_std_len`=0 leaves it as it was. `overdrive` falls for no other reason.
- R11: Any other command code makes the block go quiet until a bus reset. Later write slots, including a valid command code, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_evt | input | 1 | One-cycle pulse: bus reset/presence sequence seen |
| rst_std_len | input | 1 | With `rst_evt`: the reset pulse had standard-speed length |
| wr_bit_vld | input | 1 | One-cycle pulse: master write slot completed |
| wr_bit | input | 1 | Bit value of the write slot |
| rd_slot | input | 1 | One-cycle pulse: master read slot consumed `rd_bit` |
| alarm_in | input | 1 | Condition input for conditional search |
| overdrive | output | 1 | Fast slot timing selected |
| fn_en | output | 1 | Function layer owns the bus |
| rd_drv | output | 1 | Slave supplies the bit of the next read slot |
| rd_bit | output | 1 | Bit for the next read slot (1 when not driving) |

## Verification
A wrong state register shows up at the ports within one slot. Losing count of the bit index in a read or search phase returns a wrong identity bit, or a wrong complement, in the very next read slot. A bad branch out of command decode shows up as `fn_en` or `rd_drv` being wrong at the first sample after the eighth command bit. A mishandled mismatch appears as the bus still being driven in the next read slot, or as `fn_en` rising 64 slots later. An overdrive flag that is set or cleared at the wrong time is visible on `overdrive` one cycle after the write slot or bus reset that should, or should not, have moved it.

// File: rtl/sw_rom_pkg.sv
`timescale 1ns/1ps
package sw_rom_pkg;

    localparam int CMD_W = 8;
    typedef logic [CMD_W-1:0] cmd_t;

    // Addressing command codes
    localparam cmd_t OP_READ     = 8'h33;
    localparam cmd_t OP_MATCH    = 8'h55;
    localparam cmd_t OP_SEARCH   = 8'hF0;
    localparam cmd_t OP_CSEARCH  = 8'hEC;
    localparam cmd_t OP_SKIP     = 8'hCC;
    localparam cmd_t OP_OD_SKIP  = 8'h3C;
    localparam cmd_t OP_OD_MATCH = 8'h69;

    typedef enum logic [2:0] {
        NS_QUIET,   // ignore all slots until bus reset
        NS_CMD,     // collecting command byte
        NS_SEND,    // returning identity bits
        NS_CMP,     // comparing written bits
        NS_S_TRUE,  // search: true bit slot
        NS_S_COMP,  // search: complement slot
        NS_S_DIR,   // search: master direction slot
        NS_FUNC     // function layer enabled
    } net_state_e;

    typedef struct packed {
        net_state_e nxt;
        logic       od_set;  // set overdrive now
        logic       od_arm;  // set overdrive after a full match
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input cmd_t code, input logic alarm);
        cmd_dec_t d;
        d = '{nxt: NS_QUIET, od_set: 1'b0, od_arm: 1'b0};
        case (code)
            OP_READ:     d.nxt = NS_SEND;
            OP_MATCH:    d.nxt = NS_CMP;
            OP_SEARCH:   d.nxt = NS_S_TRUE;
            OP_CSEARCH:  d.nxt = alarm ? NS_S_TRUE : NS_QUIET;
            OP_SKIP:     d.nxt = NS_FUNC;
            OP_OD_SKIP:  begin d.nxt = NS_FUNC; d.od_set = 1'b1; end
            OP_OD_MATCH: begin d.nxt = NS_CMP;  d.od_arm = 1'b1; end
            default:     d.nxt = NS_QUIET;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sw_cmd_shift.sv
`timescale 1ns/1ps
module sw_cmd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_vld,
    input  logic         bit_in,
    output logic         byte_vld,
    output logic [W-1:0] byte_out
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-2:0]  sreg;
    logic [CW-1:0] cnt;

    // LSB first: newest bit enters at the top
    assign byte_out = {bit_in, sreg};
    assign byte_vld = en && bit_vld && (cnt == CW'(W-1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (en && bit_vld) begin
            sreg <= byte_out[W-1:1];
            cnt  <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sw_bit_pos.sv
`timescale 1ns/1ps
module sw_bit_pos #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 step,
    output logic [$clog2(N)-1:0] idx,
    output logic                 last
);
    localparam int IW = $clog2(N);

    assign last = (idx == IW'(N-1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            idx <= '0;
        else if (step)
            idx <= last ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/sw_rom_fsm.sv
`timescale 1ns/1ps
module sw_rom_fsm
    import sw_rom_pkg::*;
#(
    parameter int                  ROM_BITS = 64,
    parameter logic [ROM_BITS-1:0] ROM_ID   = '0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rst_evt,
    input  logic                        rst_std_len,
    input  logic                        wr_bit_vld,
    input  logic                        wr_bit,
    input  logic                        rd_slot,
    input  logic                        alarm_in,
    input  logic                        byte_vld,
    input  cmd_t                        byte_in,
    input  logic [$clog2(ROM_BITS)-1:0] idx,
    input  logic                        last,
    output logic                        shift_en,
    output logic                        pos_step,
    output logic                        overdrive,
    output logic                        fn_en,
    output logic                        rd_drv,
    output logic                        rd_bit
);
    net_state_e state, nxt;
    logic       od_q, od_n;
    logic       arm_q, arm_n;
    logic       my_bit;
    cmd_dec_t   dec;

    assign my_bit = ROM_ID[idx];
    assign dec    = decode_cmd(byte_in, alarm_in);

    always_comb begin
        nxt      = state;
        od_n     = od_q;
        arm_n    = arm_q;
        pos_step = 1'b0;
        case (state)
            NS_CMD: if (byte_vld) begin
                nxt   = dec.nxt;
                arm_n = dec.od_arm;
                if (dec.od_set) od_n = 1'b1;
            end
            NS_SEND: if (rd_slot) begin
                pos_step = 1'b1;
                if (last) nxt = NS_FUNC;
            end
            NS_CMP: if (wr_bit_vld) begin
                if (wr_bit != my_bit) begin
                    nxt = NS_QUIET;
                end else begin
                    pos_step = 1'b1;
                    if (last) begin
                        nxt = NS_FUNC;
                        if (arm_q) od_n = 1'b1;
                    end
                end
            end
            NS_S_TRUE: if (rd_slot) nxt = NS_S_COMP;
            NS_S_COMP: if (rd_slot) nxt = NS_S_DIR;
            NS_S_DIR: if (wr_bit_vld) begin
                if (wr_bit != my_bit) begin
                    nxt = NS_QUIET;
                end else begin
                    pos_step = 1'b1;
                    nxt      = last ? NS_FUNC : NS_S_TRUE;
                end
            end
            default: ;
        endcase
        if (rst_evt) begin
            nxt      = NS_CMD;
            arm_n    = 1'b0;
            pos_step = 1'b0;
            if (rst_std_len) od_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= NS_QUIET;
            od_q  <= 1'b0;
            arm_q <= 1'b0;
        end else begin
            state <= nxt;
            od_q  <= od_n;
            arm_q <= arm_n;
        end
    end

    assign shift_en  = (state == NS_CMD);
    assign overdrive = od_q;
    assign fn_en     = (state == NS_FUNC);
    assign rd_drv    = (state == NS_SEND) || (state == NS_S_TRUE) || (state == NS_S_COMP);
    assign rd_bit    = !rd_drv || ((state == NS_S_COMP) ? !my_bit : my_bit);
endmodule

// File: rtl/sw_rom_net.sv
`timescale 1ns/1ps
module sw_rom_net
    import sw_rom_pkg::*;
#(
    parameter int                  ROM_BITS = 64,
    parameter logic [ROM_BITS-1:0] ROM_ID   = 64'h5C0F1E2D3C4B5A21
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_evt,
    input  logic rst_std_len,
    input  logic wr_bit_vld,
    input  logic wr_bit,
    input  logic rd_slot,
    input  logic alarm_in,
    output logic overdrive,
    output logic fn_en,
    output logic rd_drv,
    output logic rd_bit
);
    localparam int IW = $clog2(ROM_BITS);

    logic          shift_en, byte_vld, pos_step, last;
    cmd_t          byte_q;
    logic [IW-1:0] idx;

    sw_cmd_shift #(.W(CMD_W)) i_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (rst_evt),
        .en       (shift_en),
        .bit_vld  (wr_bit_vld),
        .bit_in   (wr_bit),
        .byte_vld (byte_vld),
        .byte_out (byte_q)
    );

    sw_bit_pos #(.N(ROM_BITS)) i_pos (
        .clk  (clk),
        .rst  (rst),
        .clr  (rst_evt),
        .step (pos_step),
        .idx  (idx),
        .last (last)
    );

    sw_rom_fsm #(.ROM_BITS(ROM_BITS), .ROM_ID(ROM_ID)) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .rst_evt     (rst_evt),
        .rst_std_len (rst_std_len),
        .wr_bit_vld  (wr_bit_vld),
        .wr_bit      (wr_bit),
        .rd_slot     (rd_slot),
        .alarm_in    (alarm_in),
        .byte_vld    (byte_vld),
        .byte_in     (byte_q),
        .idx         (idx),
        .last        (last),
        .shift_en    (shift_en),
        .pos_step    (pos_step),
        .overdrive   (overdrive),
        .fn_en       (fn_en),
        .rd_drv      (rd_drv),
        .rd_bit      (rd_bit)
    );
endmodule

// File: rtl/sw_rom_net_chk.sv
`timescale 1ns/1ps
module sw_rom_net_chk (
    input logic clk,
    input logic rst,
    input logic rst_evt,
    input logic rst_std_len,
    input logic wr_bit_vld,
    input logic overdrive,
    input logic fn_en,
    input logic rd_drv
);
    a_r2_bus_reset_restarts: assert property (@(posedge clk) disable iff (rst)
        rst_evt |=> (!fn_en && !rd_drv));

    a_r10_long_reset_clears_od: assert property (@(posedge clk) disable iff (rst)
        (rst_evt && rst_std_len) |=> !overdrive);

    a_r10_od_falls_only_on_long_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(overdrive) |-> $past(rst_evt && rst_std_len));

    a_r8_od_rises_after_write_slot: assert property (@(posedge clk) disable iff (rst)
        $rose(overdrive) |-> $past(wr_bit_vld));

    a_r7_fn_en_held_until_reset: assert property (@(posedge clk) disable iff (rst)
        (fn_en && !rst_evt) |=> fn_en);

    a_r3_handover_releases_bus: assert property (@(posedge clk) disable iff (rst)
        fn_en |-> !rd_drv);
endmodule

bind sw_rom_net sw_rom_net_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .rst_evt     (rst_evt),
    .rst_std_len (rst_std_len),
    .wr_bit_vld  (wr_bit_vld),
    .overdrive   (overdrive),
    .fn_en       (fn_en),
    .rd_drv      (rd_drv)
);

// File: tb/test_sw_rom_net.sv
`timescale 1ns/1ps
module test_sw_rom_net;
    localparam logic [63:0] ROM = 64'h5C0F1E2D3C4B5A21;

    logic clk = 1'b0;
    logic rst, rst_evt, rst_std_len, wr_bit_vld, wr_bit, rd_slot, alarm_in;
    logic overdrive, fn_en, rd_drv, rd_bit;
    int   errs = 0;
    int   checks = 0;

    always #2.5 clk = ~clk;

    sw_rom_net #(.ROM_BITS(64), .ROM_ID(ROM)) i_sw_rom_net (
        .clk(clk), .rst(rst), .rst_evt(rst_evt), .rst_std_len(rst_std_len),
        .wr_bit_vld(wr_bit_vld), .wr_bit(wr_bit), .rd_slot(rd_slot),
        .alarm_in(alarm_in), .overdrive(overdrive), .fn_en(fn_en),
        .rd_drv(rd_drv), .rd_bit(rd_bit)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic bus_reset(input logic std_len);
        @(negedge clk); rst_evt = 1'b1; rst_std_len = std_len;
        @(negedge clk); rst_evt = 1'b0; rst_std_len = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); wr_bit_vld = 1'b1; wr_bit = b;
        @(negedge clk); wr_bit_vld = 1'b0; wr_bit = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    // Sample the slot's bit, then let the master consume it
    task automatic read_slot(output logic b, output logic d);
        @(negedge clk);
        b = rd_bit; d = rd_drv;
        rd_slot = 1'b1;
        @(negedge clk); rd_slot = 1'b0;
    endtask

    task automatic t_reset_state();
        logic b, d;
        check(!overdrive && !fn_en && !rd_drv, "R1", "outputs after reset",
              {overdrive, fn_en, rd_drv}, 0);
        read_slot(b, d);
        send_byte(8'hCC);
        @(negedge clk);
        check(!fn_en && !d && !rd_drv, "R1", "slots ignored before bus reset",
              {fn_en, d, rd_drv}, 0);
    endtask

    task automatic t_read_rom();
        logic [63:0] got;
        logic b, d;
        int bad = 0;
        bus_reset(1'b1);
        send_byte(8'h33);
        for (int i = 0; i < 64; i++) begin
            read_slot(b, d);
            got[i] = b;
            if (!d) bad++;
        end
        check(got == ROM && bad == 0, "R3", "read identity", got, ROM);
        @(negedge clk);
        check(fn_en && !rd_drv, "R3", "handover after read", {fn_en, rd_drv}, 2'b10);
    endtask

    task automatic t_match(input logic [7:0] op, input int bad_at, input string req);
        bus_reset(1'b1);
        send_byte(op);
        for (int i = 0; i < 64; i++) send_bit((i == bad_at) ? !ROM[i] : ROM[i]);
        @(negedge clk);
        if (bad_at < 0)
            check(fn_en && !rd_drv, req, "full match enables", {fn_en, rd_drv}, 2'b10);
        else
            check(!fn_en && !rd_drv, req, "mismatch goes quiet", {fn_en, rd_drv}, 0);
    endtask

    task automatic t_search(input logic [7:0] op, input int bad_at, input string req);
        logic t, c, d1, d2;
        int bad = 0;
        bus_reset(1'b1);
        send_byte(op);
        for (int i = 0; i < 64; i++) begin
            read_slot(t, d1);
            read_slot(c, d2);
            if (t != ROM[i] || c != !ROM[i] || !d1 || !d2) bad++;
            send_bit((i == bad_at) ? !ROM[i] : ROM[i]);
            if (i == bad_at) break;
        end
        check(bad == 0, req, "true/complement slots", bad, 0);
        @(negedge clk);
        if (bad_at < 0) begin
            check(fn_en, req, "search completes", fn_en, 1);
        end else begin
            read_slot(t, d1);
            check(!d1 && !fn_en, req, "dropout stops driving", {d1, fn_en}, 0);
        end
    endtask

    task automatic t_cond_search();
        logic t, c, d1, d2;
        alarm_in = 1'b0;
        bus_reset(1'b1);
        send_byte(8'hEC);
        read_slot(t, d1);
        check(!d1 && !fn_en, "R6", "no alarm: quiet", {d1, fn_en}, 0);
        alarm_in = 1'b1;
        bus_reset(1'b1);
        send_byte(8'hEC);
        read_slot(t, d1);
        read_slot(c, d2);
        check(d1 && d2 && t == ROM[0] && c == !ROM[0], "R6", "alarm: takes part",
              {d1, d2, t, c}, {2'b11, ROM[0], !ROM[0]});
        alarm_in = 1'b0;
    endtask

    task automatic t_skip_and_overdrive();
        bus_reset(1'b1);
        send_byte(8'hCC);
        check(fn_en && !overdrive, "R7", "skip enables at once", {fn_en, overdrive}, 2'b10);
        bus_reset(1'b1);
        send_byte(8'h3C);
        check(fn_en && overdrive, "R8", "overdrive skip", {fn_en, overdrive}, 2'b11);
        bus_reset(1'b0);
        check(overdrive && !fn_en, "R10", "short reset keeps overdrive", {overdrive, fn_en}, 2'b10);
        bus_reset(1'b1);
        check(!overdrive, "R10", "long reset clears overdrive", overdrive, 0);
    endtask

    task automatic t_od_match();
        t_match(8'h69, 40, "R9");
        check(!overdrive, "R9", "mismatch leaves overdrive clear", overdrive, 0);
        t_match(8'h69, -1, "R9");
        check(overdrive, "R9", "full match sets overdrive", overdrive, 1);
        bus_reset(1'b1);
    endtask

    task automatic t_unknown_and_restart();
        logic b, d;
        bus_reset(1'b1);
        send_byte(8'hA5);
        send_byte(8'hCC);
        read_slot(b, d);
        check(!fn_en && !d && b, "R11", "unknown code ignores later slots", {fn_en, d, b}, 3'b001);
        bus_reset(1'b1);
        send_byte(8'h33);
        read_slot(b, d);
        read_slot(b, d);
        bus_reset(1'b1);
        check(!fn_en && !rd_drv, "R2", "reset aborts read", {fn_en, rd_drv}, 0);
        send_byte(8'h33);
        read_slot(b, d);
        check(d && b == ROM[0], "R2", "new command restarts at bit 0", {d, b}, {1'b1, ROM[0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst = 1'b1; rst_evt = 1'b0; rst_std_len = 1'b0;
        wr_bit_vld = 1'b0; wr_bit = 1'b0; rd_slot = 1'b0; alarm_in = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_read_rom();
        t_match(8'h55, -1, "R4");
        t_match(8'h55, 10, "R4");
        t_search(8'hF0, -1, "R5");
        t_search(8'hF0, 5, "R5");
        t_cond_search();
        t_skip_and_overdrive();
        t_od_match();
        t_unknown_and_restart();
        summary();
    end
endmodule